// File: doc/BRIEF.md
# TLB Special-Register Access Unit

This unit keeps a software-managed translation buffer and serves the move-to and move-from special-register accesses that load and inspect it. Each entry is made of a 32-bit HI word, a 64-bit LO word and an 8-bit tag ID. Two control registers sit alongside the arrays. The index register selects the entry that HI and LO accesses touch. The process-ID register supplies the tag stored on a HI write, and it receives the tag read back on a HI read.

Each request gives the 32-bit immediate of the instruction and, for writes, a 32-bit data word. The unit decodes the immediate to find the direction, the register number and an extended-access flag. The flag lets a 32-bit port reach the upper half of a 64-bit LO word. Any access the unit does not accept is dropped without changing state. A HI write raises a one-cycle invalidate pulse that carries the entry index, so a translation cache elsewhere can discard its copy of that entry.

Top module: `tlb_sreg_unit`

## Requirements
- R1: A request is for this unit only when bits 13:8 of the immediate equal 6'b010000. Bits 7:0 are not used for this match. A request that does not match changes no state and produces no read response.
- R2: Immediate bit 14 gives the direction: 1 for a write, 0 for a read. The extended flag is immediate bit 24 on a write and immediate bit 19 on a read. The bit at the other position is ignored.
- R3: When parameter ADDR_W is 32 or less, the extended flag is always treated as 0.
- R4: The register number is immediate bits 2:0. Register 0 is the process ID and register 2 is the index. Register 3 is LO and register 4 is HI, so bit 0 of the number separates the two arrays. The process ID and the index hold the low 8 bits of write data and read back zero-extended. Every other register number reads 0 and ignores writes.
- R5: An extended LO access reads or replaces bits 63:32 of the selected entry. A plain LO access reads or replaces bits 31:0. A write leaves the other half unchanged.
- R6: An extended access to any register other than LO changes nothing, and if it is a read it returns 0.
- R7: A HI read of an in-range entry loads that entry's tag ID into the process-ID register.
- R8: A HI write of an in-range entry stores the current process ID as that entry's tag. In the next cycle inval_valid is high for exactly one cycle, with inval_index equal to the index.
- R9: With parameter MMU_ON at 0, every accepted read returns 0, no state changes and no invalidate pulse occurs.
- R10: An index of ENTRIES (64) or more makes HI and LO reads return 0. HI and LO writes at such an index are ignored, give no invalidate pulse and do not load the process ID.
- R11: rd_valid is high in the cycle after each matching read request and at no other time, with rd_data valid in that same cycle. Writes take effect at the clock edge of the request.
- R12: A synchronous reset clears the index, the process ID, every tag and every HI and LO word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_imm | input | 32 | Instruction immediate: register field, direction and extended flag |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| inval_valid | output | 1 | One-cycle pulse after a HI write |
| inval_index | output | 8 | Entry index of the invalidate pulse |

## Verification
The bench sets the extended-flag bit for the opposite direction to random values. A design that read the flag from the wrong position would then corrupt the wrong LO half or reject legal accesses. It also alternates upper-half and lower-half writes to the same entry. A design that replaced the whole 64-bit word would lose the half that was not written. Extended accesses to the process ID and the index are checked to leave both registers unchanged and to read 0. The same stimulus goes to a narrow-address instance, which must treat those accesses as plain ones. Index values at and beyond the array size, the PID copy on a HI read and the tag taken on a HI write are all exercised. A design that wrapped the index or reversed the tag transfer would return wrong data on later reads.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;

  localparam logic [13:0] SR_BLOCK_BASE = 14'h1000;
  localparam logic [13:0] SR_BLOCK_MASK = 14'h3f00;

  localparam logic [2:0] RN_PID = 3'd0;
  localparam logic [2:0] RN_IDX = 3'd2;
  localparam logic [2:0] RN_LO  = 3'd3;
  localparam logic [2:0] RN_HI  = 3'd4;

  localparam int DIR_POS    = 14;
  localparam int EXT_POS_WR = 24;
  localparam int EXT_POS_RD = 19;

  typedef struct packed {
    logic       hit;
    logic       wr;
    logic       ext;
    logic [2:0] rn;
  } sr_acc_t;

  // Splits an immediate into the fields the unit acts on.
  function automatic sr_acc_t decode_imm(input logic [31:0] imm, input logic wide);
    sr_acc_t a;
    a.hit = ((imm[13:0] & SR_BLOCK_MASK) == SR_BLOCK_BASE);
    a.wr  = imm[DIR_POS];
    a.rn  = imm[2:0];
    a.ext = wide & (a.wr ? imm[EXT_POS_WR] : imm[EXT_POS_RD]);
    return a;
  endfunction

  // Replaces one 32-bit half of a 64-bit word.
  function automatic logic [63:0] put_half(input logic [63:0] old, input logic upper,
                                           input logic [31:0] v);
    return upper ? {v, old[31:0]} : {old[63:32], v};
  endfunction

  function automatic logic [31:0] get_half(input logic [63:0] w, input logic upper);
    return upper ? w[63:32] : w[31:0];
  endfunction

endpackage

// File: rtl/tlb_sreg_decode.sv
module tlb_sreg_decode
  import tlb_sreg_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter bit MMU_ON = 1'b1
) (
  input  logic        req_valid,
  input  logic [31:0] req_imm,
  output logic        acc_rd,
  output logic        acc_wr,
  output logic        acc_ext,
  output logic [2:0]  acc_rn,
  output logic        acc_legal
);

  logic    wide;
  sr_acc_t acc;

  generate
    if (ADDR_W > 32) begin : g_wide
      assign wide = 1'b1;
    end else begin : g_narrow
      assign wide = 1'b0;
    end
  endgenerate

  always_comb begin
    acc       = decode_imm(req_imm, wide);
    acc_rd    = req_valid & acc.hit & ~acc.wr;
    acc_wr    = req_valid & acc.hit & acc.wr;
    acc_ext   = acc.ext;
    acc_rn    = acc.rn;
    acc_legal = MMU_ON & ~(acc.ext & (acc.rn != RN_LO));
  end

endmodule

// File: rtl/tlb_sreg_ctrl_regs.sv
module tlb_sreg_ctrl_regs #(
  parameter int IDX_W = 8,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_we,
  input  logic             pid_we,
  input  logic [7:0]       wbyte,
  input  logic             pid_ld,
  input  logic [PID_W-1:0] pid_ld_val,
  output logic [IDX_W-1:0] idx_q,
  output logic [PID_W-1:0] pid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      pid_q <= '0;
    end else begin
      if (idx_we) idx_q <= IDX_W'(wbyte);
      if (pid_we) pid_q <= PID_W'(wbyte);
      else if (pid_ld) pid_q <= pid_ld_val;
    end
  end

endmodule

// File: rtl/tlb_sreg_arrays.sv
module tlb_sreg_arrays
  import tlb_sreg_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8,
  parameter int PID_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic             upper,
  input  logic [31:0]      wdata,
  input  logic [PID_W-1:0] pid,
  output logic             idx_ok,
  output logic [31:0]      lo_half,
  output logic [31:0]      hi_word,
  output logic [PID_W-1:0] tag_word,
  output logic             inval_valid,
  output logic [IDX_W-1:0] inval_index
);

  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W:0] ENT_LIM = (IDX_W+1)'(ENTRIES);

  logic [63:0]      lo_mem  [ENTRIES];
  logic [31:0]      hi_mem  [ENTRIES];
  logic [PID_W-1:0] tag_mem [ENTRIES];
  logic [AW-1:0]    slot;
  logic             inval_q;
  logic [IDX_W-1:0] inval_idx_q;

  assign idx_ok = ({1'b0, idx} < ENT_LIM);
  assign slot   = idx[AW-1:0];

  always_comb begin
    lo_half  = idx_ok ? get_half(lo_mem[slot], upper) : 32'd0;
    hi_word  = idx_ok ? hi_mem[slot] : 32'd0;
    tag_word = idx_ok ? tag_mem[slot] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        lo_mem[i]  <= '0;
        hi_mem[i]  <= '0;
        tag_mem[i] <= '0;
      end
      inval_q     <= 1'b0;
      inval_idx_q <= '0;
    end else begin
      inval_q     <= hi_we & idx_ok;
      inval_idx_q <= idx;
      if (lo_we && idx_ok) lo_mem[slot] <= put_half(lo_mem[slot], upper, wdata);
      if (hi_we && idx_ok) begin
        hi_mem[slot]  <= wdata;
        tag_mem[slot] <= pid;
      end
    end
  end

  assign inval_valid = inval_q;
  assign inval_index = inval_idx_q;

endmodule

// File: rtl/tlb_sreg_unit.sv
module tlb_sreg_unit
  import tlb_sreg_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter bit MMU_ON  = 1'b1,
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_imm,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        inval_valid,
  output logic [7:0]  inval_index
);

  localparam int IDX_W = 8;
  localparam int PID_W = 8;

  logic             acc_rd, acc_wr, acc_ext, acc_legal;
  logic [2:0]       acc_rn;
  logic             rd_ok, wr_ok;
  logic             idx_we, pid_we, pid_ld, lo_we, hi_we;
  logic [IDX_W-1:0] idx_q;
  logic [PID_W-1:0] pid_q;
  logic             idx_ok;
  logic [31:0]      lo_half, hi_word;
  logic [PID_W-1:0] tag_word;
  logic [31:0]      rd_mux;
  logic             rd_valid_q;
  logic [31:0]      rd_data_q;

  tlb_sreg_decode #(.ADDR_W(ADDR_W), .MMU_ON(MMU_ON)) u_dec (
    .req_valid (req_valid),
    .req_imm   (req_imm),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_ext   (acc_ext),
    .acc_rn    (acc_rn),
    .acc_legal (acc_legal)
  );

  assign rd_ok  = acc_rd & acc_legal;
  assign wr_ok  = acc_wr & acc_legal;
  assign idx_we = wr_ok & (acc_rn == RN_IDX);
  assign pid_we = wr_ok & (acc_rn == RN_PID);
  assign lo_we  = wr_ok & (acc_rn == RN_LO);
  assign hi_we  = wr_ok & (acc_rn == RN_HI);
  assign pid_ld = rd_ok & (acc_rn == RN_HI) & idx_ok;

  tlb_sreg_ctrl_regs #(.IDX_W(IDX_W), .PID_W(PID_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .idx_we     (idx_we),
    .pid_we     (pid_we),
    .wbyte      (req_wdata[7:0]),
    .pid_ld     (pid_ld),
    .pid_ld_val (tag_word),
    .idx_q      (idx_q),
    .pid_q      (pid_q)
  );

  tlb_sreg_arrays #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .PID_W(PID_W)) u_arr (
    .clk         (clk),
    .rst         (rst),
    .idx         (idx_q),
    .lo_we       (lo_we),
    .hi_we       (hi_we),
    .upper       (acc_ext),
    .wdata       (req_wdata),
    .pid         (pid_q),
    .idx_ok      (idx_ok),
    .lo_half     (lo_half),
    .hi_word     (hi_word),
    .tag_word    (tag_word),
    .inval_valid (inval_valid),
    .inval_index (inval_index)
  );

  always_comb begin
    rd_mux = 32'd0;
    if (acc_legal) begin
      case (acc_rn)
        RN_PID:  rd_mux = 32'(pid_q);
        RN_IDX:  rd_mux = 32'(idx_q);
        RN_LO:   rd_mux = lo_half;
        RN_HI:   rd_mux = hi_word;
        default: rd_mux = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= 32'd0;
    end else begin
      rd_valid_q <= acc_rd;
      if (acc_rd) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/tlb_sreg_checker.sv
module tlb_sreg_checker
  import tlb_sreg_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter bit MMU_ON  = 1'b1,
  parameter int ENTRIES = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_imm,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        inval_valid,
  input logic [7:0]  inval_index,
  input logic        pid_ld
);

  localparam logic WIDE = (ADDR_W > 32);

  sr_acc_t a;
  logic    rd_req, wr_req;

  always_comb begin
    a      = decode_imm(req_imm, WIDE);
    rd_req = req_valid & a.hit & ~a.wr;
    wr_req = req_valid & a.hit & a.wr;
  end

  // R11: a read request is answered in the next cycle
  p_rd_follows_r11: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);

  // R1: no response without a matching read
  p_rd_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);

  // R8: an invalidate pulse only follows a HI write
  p_inval_src_r8: assert property (@(posedge clk) disable iff (rst)
    inval_valid |-> $past(wr_req && a.rn == RN_HI));

  // R10: pulses never name an entry beyond the array
  p_inval_range_r10: assert property (@(posedge clk) disable iff (rst)
    inval_valid |-> (int'(inval_index) < ENTRIES));

  // R6: extended reads of anything but LO return zero
  p_ext_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && a.ext && a.rn != RN_LO) |=> (rd_data == 32'd0));

  // R9: an absent unit answers zero and never invalidates
  p_absent_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (!MMU_ON && rd_valid) |-> (rd_data == 32'd0 && !inval_valid));

  // R7: the PID load only happens on a HI read
  p_pid_copy_r7: assert property (@(posedge clk) disable iff (rst)
    pid_ld |-> (rd_req && a.rn == RN_HI));

  // R4: the index register reads back zero-extended
  p_idx_width_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && a.rn == RN_IDX && !a.ext) |=> (rd_data[31:8] == 24'd0));

endmodule

bind tlb_sreg_unit tlb_sreg_checker #(
  .ADDR_W(ADDR_W), .MMU_ON(MMU_ON), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm),
  .rd_valid(rd_valid), .rd_data(rd_data), .inval_valid(inval_valid),
  .inval_index(inval_index), .pid_ld(pid_ld)
);

// File: tb/tlb_sreg_unit_bench.sv
`timescale 1ns/1ps
module tlb_sreg_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_imm = '0;
  logic [31:0] req_wdata = '0;

  logic        rv_m, rv_n, rv_a;
  logic [31:0] rd_m, rd_n, rd_a;
  logic        iv_m, iv_n, iv_a;
  logic [7:0]  ii_m, ii_n, ii_a;

  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  tlb_sreg_unit u_tlb_sreg_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm),
    .req_wdata(req_wdata), .rd_valid(rv_m), .rd_data(rd_m),
    .inval_valid(iv_m), .inval_index(ii_m));

  tlb_sreg_unit #(.ADDR_W(32)) u_narrow (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm),
    .req_wdata(req_wdata), .rd_valid(rv_n), .rd_data(rd_n),
    .inval_valid(iv_n), .inval_index(ii_n));

  tlb_sreg_unit #(.MMU_ON(1'b0)) u_absent (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_imm(req_imm),
    .req_wdata(req_wdata), .rd_valid(rv_a), .rd_data(rd_a),
    .inval_valid(iv_a), .inval_index(ii_a));

  // Bench model: copy 0 has a wide address, copy 1 a 32-bit one.
  logic [63:0] m_lo  [2][64];
  logic [31:0] m_hi  [2][64];
  logic [7:0]  m_tag [2][64];
  logic [7:0]  m_idx [2];
  logic [7:0]  m_pid [2];

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_idx[d] = 8'd0;
      m_pid[d] = 8'd0;
      for (int i = 0; i < 64; i++) begin
        m_lo[d][i] = 64'd0; m_hi[d][i] = 32'd0; m_tag[d][i] = 8'd0;
      end
    end
  endtask

  task automatic model_step(input int d, input logic [31:0] imm, input logic [31:0] wd,
                            output logic rv, output logic [31:0] rd,
                            output logic iv, output logic [7:0] ii);
    logic       hit, wr, ext, ok;
    logic [2:0] n;
    int         e;
    hit = (imm[13:8] == 6'b010000);
    wr  = imm[14];
    ext = (d == 0) && (wr ? imm[24] : imm[19]);
    n   = imm[2:0];
    e   = int'(m_idx[d]);
    ok  = (e < 64);
    rv = hit && !wr; rd = 32'd0; iv = 1'b0; ii = 8'd0;
    if (hit && !(ext && n != 3'd3)) begin
      if (!wr) begin
        case (n)
          3'd0: rd = {24'd0, m_pid[d]};
          3'd2: rd = {24'd0, m_idx[d]};
          3'd3: if (ok) rd = ext ? m_lo[d][e][63:32] : m_lo[d][e][31:0];
          3'd4: if (ok) begin rd = m_hi[d][e]; m_pid[d] = m_tag[d][e]; end
          default: rd = 32'd0;
        endcase
      end else begin
        case (n)
          3'd0: m_pid[d] = wd[7:0];
          3'd2: m_idx[d] = wd[7:0];
          3'd3: if (ok) begin
                  if (ext) m_lo[d][e][63:32] = wd; else m_lo[d][e][31:0] = wd;
                end
          3'd4: if (ok) begin
                  m_hi[d][e] = wd; m_tag[d][e] = m_pid[d]; iv = 1'b1; ii = m_idx[d];
                end
          default: ;
        endcase
      end
    end
  endtask

  // Called at a falling edge; checks responses at the next falling edge.
  task automatic apply(input logic [31:0] imm, input logic [31:0] wd, input string tag);
    logic        erv [2];
    logic [31:0] erd [2];
    logic        eiv [2];
    logic [7:0]  eii [2];
    string       ntag;
    for (int d = 0; d < 2; d++) model_step(d, imm, wd, erv[d], erd[d], eiv[d], eii[d]);
    req_imm = imm; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ntag = (imm[24] | imm[19]) ? {tag, "/R3"} : tag;
    chk({tag, "/R11"}, "rd_valid", 32'(rv_m), 32'(erv[0]));
    if (erv[0]) chk(tag, "rd_data", rd_m, erd[0]);
    chk(tag, "inval_valid", 32'(iv_m), 32'(eiv[0]));
    if (eiv[0]) chk(tag, "inval_index", 32'(ii_m), 32'(eii[0]));
    chk(ntag, "narrow rd_valid", 32'(rv_n), 32'(erv[1]));
    if (erv[1]) chk(ntag, "narrow rd_data", rd_n, erd[1]);
    chk(ntag, "narrow inval_valid", 32'(iv_n), 32'(eiv[1]));
    if (eiv[1]) chk(ntag, "narrow inval_index", 32'(ii_n), 32'(eii[1]));
    chk("R9", "absent rd_valid", 32'(rv_a), 32'(erv[0]));
    if (erv[0]) chk("R9", "absent rd_data", rd_a, 32'd0);
    chk("R9", "absent inval_valid", 32'(iv_a), 32'd0);
  endtask

  function automatic logic [31:0] mk_imm(input logic wr, input logic ext, input logic [2:0] rn,
                                         input logic hit, input logic junk);
    logic [31:0] imm;
    imm = $urandom();
    imm[13:8] = hit ? 6'h10 : (6'h10 ^ (6'h01 << ($urandom() % 6)));
    imm[14] = wr;
    imm[24] = wr ? ext : junk;
    imm[19] = wr ? junk : ext;
    imm[2:0] = rn;
    return imm;
  endfunction

  function automatic string tag_of(input logic [31:0] imm);
    logic ext;
    ext = imm[14] ? imm[24] : imm[19];
    if (imm[13:8] != 6'h10) return "R1";
    if (ext && imm[2:0] != 3'd3) return "R6";
    if ((imm[2:0] == 3'd3 || imm[2:0] == 3'd4) && m_idx[0] >= 8'd64) return "R10";
    if (imm[2:0] == 3'd4) return imm[14] ? "R8" : "R7";
    if (imm[2:0] == 3'd3) return "R5";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12", "rd_valid after reset", 32'(rv_m), 32'd0);
    chk("R12", "inval after reset", 32'(iv_m), 32'd0);
    // R12: everything reads zero after reset
    apply(mk_imm(0, 0, 3'd0, 1, 0), 0, "R12");
    apply(mk_imm(0, 0, 3'd2, 1, 0), 0, "R12");
    apply(mk_imm(0, 0, 3'd3, 1, 0), 0, "R12");
    apply(mk_imm(0, 1, 3'd3, 1, 0), 0, "R12");
    apply(mk_imm(0, 0, 3'd4, 1, 0), 0, "R12");
    // R4: register numbers, index select
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'hffff_ff05, "R4");
    apply(mk_imm(0, 0, 3'd2, 1, 0), 0, "R4");
    apply(mk_imm(1, 0, 3'd3, 1, 0), 32'haaaa_0001, "R4");
    apply(mk_imm(1, 0, 3'd1, 1, 0), 32'h1234_5678, "R4");
    apply(mk_imm(0, 0, 3'd1, 1, 0), 0, "R4");
    // R8: HI write takes PID as tag and pulses
    apply(mk_imm(1, 0, 3'd0, 1, 0), 32'h0000_013c, "R8");
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'd6, "R8");
    apply(mk_imm(1, 0, 3'd4, 1, 0), 32'hc0de_0006, "R8");
    apply(mk_imm(1, 0, 3'd4, 1, 0), 32'hc0de_0007, "R8");
    // R7: HI read loads tag into PID
    apply(mk_imm(1, 0, 3'd0, 1, 0), 32'd0, "R7");
    apply(mk_imm(0, 0, 3'd4, 1, 0), 0, "R7");
    apply(mk_imm(0, 0, 3'd0, 1, 0), 0, "R7");
    // R5 and R2: halves of LO with junk in the other flag position
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'd5, "R5");
    apply(mk_imm(1, 1, 3'd3, 1, 1), 32'hdddd_0002, "R2");
    apply(mk_imm(0, 0, 3'd3, 1, 1), 0, "R2");
    apply(mk_imm(0, 1, 3'd3, 1, 1), 0, "R5");
    apply(mk_imm(1, 0, 3'd3, 1, 1), 32'heeee_0003, "R2");
    apply(mk_imm(0, 1, 3'd3, 1, 0), 0, "R5");
    apply(mk_imm(0, 0, 3'd3, 1, 0), 0, "R5");
    // R6: extended access to other registers
    apply(mk_imm(1, 1, 3'd0, 1, 0), 32'h77, "R6");
    apply(mk_imm(1, 1, 3'd2, 1, 0), 32'h33, "R6");
    apply(mk_imm(1, 1, 3'd4, 1, 0), 32'h99, "R6");
    apply(mk_imm(0, 0, 3'd0, 1, 0), 0, "R6");
    apply(mk_imm(0, 0, 3'd2, 1, 0), 0, "R6");
    apply(mk_imm(0, 1, 3'd2, 1, 0), 0, "R6");
    apply(mk_imm(0, 1, 3'd4, 1, 0), 0, "R6");
    // R10: index boundary
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'd63, "R10");
    apply(mk_imm(1, 0, 3'd4, 1, 0), 32'h6363_6363, "R10");
    apply(mk_imm(0, 0, 3'd4, 1, 0), 0, "R10");
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'd64, "R10");
    apply(mk_imm(1, 0, 3'd3, 1, 0), 32'hbad0_0040, "R10");
    apply(mk_imm(1, 0, 3'd4, 1, 0), 32'hbad1_0040, "R10");
    apply(mk_imm(0, 0, 3'd3, 1, 0), 0, "R10");
    apply(mk_imm(0, 0, 3'd4, 1, 0), 0, "R10");
    apply(mk_imm(0, 0, 3'd0, 1, 0), 0, "R10");
    apply(mk_imm(1, 0, 3'd2, 1, 0), 32'd0, "R10");
    apply(mk_imm(0, 0, 3'd3, 1, 0), 0, "R10");
    // R1: a near-miss block field is ignored
    apply(mk_imm(1, 0, 3'd2, 0, 0), 32'd9, "R1");
    apply(mk_imm(0, 0, 3'd2, 0, 0), 0, "R1");
    apply(mk_imm(0, 0, 3'd2, 1, 0), 0, "R1");
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] imm, wd;
      logic [2:0]  rn;
      rn  = ($urandom() % 3 == 0) ? 3'($urandom()) : ((($urandom() % 2) == 0) ? 3'd3 : 3'd4);
      if ($urandom() % 5 == 0) rn = ($urandom() % 2 == 0) ? 3'd2 : 3'd0;
      imm = mk_imm(1'($urandom()), ($urandom() % 3 == 0), rn, ($urandom() % 10 != 0),
                   1'($urandom()));
      wd  = $urandom();
      if (rn == 3'd2 && ($urandom() % 4 != 0)) wd = $urandom() % 72;
      apply(imm, wd, tag_of(imm));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule